// File: doc/BRIEF.md
# Alternate-Frame Pixel Phase Controller

This block lets a capture path take video whose pixel rate is too high to convert at full speed. In alternate mode it keeps only every second pixel of each line, so samples leave at half the pixel rate. The choice of which pixels are kept swaps from frame to frame: one frame carries the odd pixels of every line and the next frame carries the even ones. A later stage rebuilds full frames from the two halves. When alternate mode is off, every pixel is passed through.

The selection phase normally flips once per frame, on the vertical sync edge. A manual invert input gives a further half-rate phase shift. Either kind of change is accepted only while vertical blanking is active, so the phase never moves in the middle of a picture. A phase change can corrupt the samples taken just after it. For that reason, each change marks a programmable number of the following samples as not valid. Every sample carries a registered flag that says which phase it belongs to, so the rebuilding stage can tell the frames apart.

Top module: `altpix_phase_ctrl`

## Requirements
- R1: While reset is held, and before any stimulus after it, `smp_stb` and `smp_valid` are 0 and `smp_phase_odd` is 1. Reset leaves the phase at odd (1), the auto-flip disarmed, no flip pending and the settle counter at zero.
- R2: With `alt_en` = 0, every cycle with `pix_en` = 1 produces `smp_stb` = 1 on the next cycle. Cycles without `pix_en` produce no strobe.
- R3: With `alt_en` = 1, a pixel is taken only if its parity matches the phase. The pixel that carries `line_start` (together with `pix_en`) is pixel 1, which is odd, and parity alternates on each later enabled pixel. Phase 1 takes the odd pixels and phase 0 takes the even ones. A line of 2N enabled pixels therefore gives exactly N strobes.
- R4: `smp_data` holds the `pix_data` of the taken pixel. Together with `smp_stb`, it is registered one cycle after the `pix_en` cycle.
- R5: After the block is armed, a rising edge of `vsync` seen in a cycle with `vblank` = 1 flips the phase. The block becomes armed in the first cycle that has `vblank` = 1, and an edge in that same cycle does not count.
- R6: An armed rising edge of `vsync` seen while `vblank` = 0 does not flip the phase at once. The flip is held pending and happens in the next cycle that has `vblank` = 1.
- R7: Rising edges of `vsync` that arrive before the first `vblank` cycle after reset have no effect on the phase.
- R8: `inv_in` = 1 inverts the phase. `inv_in` is latched only in cycles with `vblank` = 1, so changes made while `vblank` = 0 have no effect until the next blanking cycle.
- R9: Each phase change loads `settle_len`. The next `settle_len` strobes come out with `smp_valid` = 0, and strobes after those have `smp_valid` = 1. With `settle_len` = 0 no strobe is invalid. `smp_valid` is never 1 without `smp_stb`.
- R10: `smp_phase_odd` gives the phase that was in force when the strobed pixel was taken, and it holds its value between strobes.
- R11: With `alt_en` = 0, `vsync` edges do not flip the phase and `inv_in` is latched as 0, so the phase can change only by dropping an earlier invert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pix_en | input | 1 | Full-rate pixel enable, one per incoming pixel |
| pix_data | input | DW | Pixel data, qualified by `pix_en` |
| line_start | input | 1 | Marks the first pixel of a line; it is given together with `pix_en` |
| vsync | input | 1 | Vertical sync, active high |
| vblank | input | 1 | Vertical blanking indicator, active high |
| alt_en | input | 1 | 1 = alternate half-rate mode, 0 = pass every pixel |
| inv_in | input | 1 | Manual phase invert, latched during blanking |
| settle_len | input | SW | Number of strobes marked not valid after each phase change |
| smp_stb | output | 1 | Sample strobe |
| smp_data | output | DW | Sampled pixel data |
| smp_valid | output | 1 | Sample is usable, meaning the phase has settled |
| smp_phase_odd | output | 1 | Phase of the sample: 1 = odd, 0 = even |

## Verification
The assertions check the following on every cycle:
- the valid flag never appears without a strobe;
- a strobe always follows a pixel enable;
- in pass-through mode each pixel maps to a strobe that carries its data;
- the phase moves only right after a blanking cycle;
- the first pixel of a line can be taken only in the odd phase.

Only the bench's scenarios can show the rest. These are:
- that a flip outside blanking is deferred to the next blanking interval;
- that `vsync` edges before the first blanking cycle are ignored;
- that the manual invert is latched only during blanking;
- the exact number of invalid strobes after a change, across every settle length and several pixel-enable patterns.

// File: rtl/altpix_pkg.sv
package altpix_pkg;
  // Registered per-sample flags driven to the output ports
  typedef struct packed {
    logic stb;
    logic valid;
    logic odd;
  } smp_flags_t;
endpackage

// File: rtl/altpix_rst_sync.sv
module altpix_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  generate
    if (STAGES <= 1) begin : g_one
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= 1'b1;
      end
      assign rst_sn = q;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], 1'b1};
      end
      assign rst_sn = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/altpix_parity.sv
module altpix_parity (
  input  logic clk,
  input  logic rst_sn,
  input  logic pix_en,
  input  logic line_start,
  output logic cur_odd
);
  logic nxt_odd_q, nxt_odd_d, nxt_en;

  // Pixel 1 of a line is odd; parity alternates per enabled pixel
  assign cur_odd = line_start | nxt_odd_q;

  always_comb begin
    nxt_en    = pix_en | line_start;
    nxt_odd_d = pix_en ? ~cur_odd : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     nxt_odd_q <= 1'b1;
    else if (nxt_en) nxt_odd_q <= nxt_odd_d;
  end
endmodule

// File: rtl/altpix_phase.sv
module altpix_phase (
  input  logic clk,
  input  logic rst_sn,
  input  logic vsync,
  input  logic vblank,
  input  logic alt_en,
  input  logic inv_in,
  output logic phase_odd,
  output logic flip
);
  logic vs_q, armed_q, pend_q, auto_q, inv_q;
  logic armed_d, pend_d, auto_d, inv_d;
  logic vs_rise, tog;

  assign vs_rise = vsync & ~vs_q;

  always_comb begin
    tog     = alt_en & armed_q & vblank & (vs_rise | pend_q);
    armed_d = armed_q | vblank;
    auto_d  = auto_q ^ tog;
    inv_d   = vblank ? (inv_in & alt_en) : inv_q;
    if (!alt_en || tog)               pend_d = 1'b0;
    else if (armed_q && vs_rise)      pend_d = 1'b1;
    else                              pend_d = pend_q;
  end

  // Phase is odd when the auto flips and manual invert cancel out
  assign phase_odd = ~(auto_q ^ inv_q);
  assign flip      = (auto_d ^ inv_d) != (auto_q ^ inv_q);

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      vs_q    <= 1'b0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      auto_q  <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      vs_q    <= vsync;
      armed_q <= armed_d;
      pend_q  <= pend_d;
      auto_q  <= auto_d;
      inv_q   <= inv_d;
    end
  end
endmodule

// File: rtl/altpix_settle.sv
module altpix_settle #(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          flip,
  input  logic          stb,
  input  logic [SW-1:0] settle_len,
  output logic          settled
);
  logic [SW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign settled = (cnt_q == '0);

  always_comb begin
    cnt_en = flip | (stb & ~settled);
    cnt_d  = flip ? settle_len : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/altpix_phase_ctrl.sv
module altpix_phase_ctrl
  import altpix_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic [DW-1:0] pix_data,
  input  logic          line_start,
  input  logic          vsync,
  input  logic          vblank,
  input  logic          alt_en,
  input  logic          inv_in,
  input  logic [SW-1:0] settle_len,
  output logic          smp_stb,
  output logic [DW-1:0] smp_data,
  output logic          smp_valid,
  output logic          smp_phase_odd
);
  logic rst_sn;
  logic cur_odd;
  logic phase_odd_q;
  logic flip;
  logic take;
  logic settled;

  altpix_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  altpix_parity u_par (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .pix_en     (pix_en),
    .line_start (line_start),
    .cur_odd    (cur_odd)
  );

  altpix_phase u_ph (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .vsync     (vsync),
    .vblank    (vblank),
    .alt_en    (alt_en),
    .inv_in    (inv_in),
    .phase_odd (phase_odd_q),
    .flip      (flip)
  );

  assign take = pix_en & (~alt_en | (cur_odd == phase_odd_q));

  altpix_settle #(.SW(SW)) u_st (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .flip       (flip),
    .stb        (take),
    .settle_len (settle_len),
    .settled    (settled)
  );

  smp_flags_t    flg_d, flg_q;
  logic [DW-1:0] data_q;

  always_comb begin
    flg_d.stb   = take;
    flg_d.valid = take & settled;
    flg_d.odd   = take ? phase_odd_q : flg_q.odd;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) flg_q <= '{stb: 1'b0, valid: 1'b0, odd: 1'b1};
    else         flg_q <= flg_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)   data_q <= '0;
    else if (take) data_q <= pix_data;
  end

  assign smp_stb       = flg_q.stb;
  assign smp_valid     = flg_q.valid;
  assign smp_phase_odd = flg_q.odd;
  assign smp_data      = data_q;
endmodule

// File: rtl/altpix_chk.sv
module altpix_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_ok,
  input logic          pix_en,
  input logic [DW-1:0] pix_data,
  input logic          line_start,
  input logic          vblank,
  input logic          alt_en,
  input logic          smp_stb,
  input logic [DW-1:0] smp_data,
  input logic          smp_valid,
  input logic          smp_phase_odd,
  input logic          phase_now
);
  AST_VALID_HAS_STB: assert property (@(posedge clk) disable iff (!rst_ok)
    smp_valid |-> smp_stb); // R9

  AST_STB_FOLLOWS_PIX: assert property (@(posedge clk) disable iff (!rst_ok)
    smp_stb |-> $past(pix_en)); // R4

  AST_FULL_RATE_STB: assert property (@(posedge clk) disable iff (!rst_ok)
    (!alt_en && pix_en) |=> smp_stb); // R2

  AST_FULL_RATE_DATA: assert property (@(posedge clk) disable iff (!rst_ok)
    (!alt_en && pix_en) |=> (smp_data == $past(pix_data))); // R4

  AST_FLIP_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_ok)
    !$stable(phase_now) |-> $past(vblank)); // R8

  AST_FIRST_PIX_ODD: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(alt_en && line_start && pix_en) && smp_stb) |-> smp_phase_odd); // R3
endmodule

bind altpix_phase_ctrl altpix_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_ok        (rst_sn),
  .pix_en        (pix_en),
  .pix_data      (pix_data),
  .line_start    (line_start),
  .vblank        (vblank),
  .alt_en        (alt_en),
  .smp_stb       (smp_stb),
  .smp_data      (smp_data),
  .smp_valid     (smp_valid),
  .smp_phase_odd (smp_phase_odd),
  .phase_now     (phase_odd_q)
);

// File: tb/sim_altpix_phase_ctrl.sv
`timescale 1ns/1ps
module sim_altpix_phase_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pix_en, line_start, vsync, vblank, alt_en, inv_in;
  logic [7:0] pix_data;
  logic [2:0] settle_len;
  logic       smp_stb, smp_valid, smp_phase_odd;
  logic [7:0] smp_data;

  always #10 clk = ~clk;

  altpix_phase_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pix_data(pix_data),
    .line_start(line_start), .vsync(vsync), .vblank(vblank),
    .alt_en(alt_en), .inv_in(inv_in), .settle_len(settle_len),
    .smp_stb(smp_stb), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_phase_odd(smp_phase_odd)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state, written from the requirements
  bit m_vsq, m_armed, m_pend, m_auto, m_inv, m_nxt;
  int m_cnt;
  bit last_ph;
  int stb_cnt, bad_cnt;
  string tag;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  function automatic bit m_odd();
    return !(m_auto ^ m_inv);
  endfunction

  task automatic model_reset();
    m_vsq = 0; m_armed = 0; m_pend = 0; m_auto = 0; m_inv = 0; m_nxt = 1; m_cnt = 0;
  endtask

  task automatic step(input bit pe, input bit ls, input bit vs, input bit vb, input logic [7:0] d);
    bit cur, e_stb, rise, tog, old_odd;
    pix_en = pe; line_start = ls; vsync = vs; vblank = vb; pix_data = d;
    @(posedge clk);
    @(negedge clk);
    cur   = ls | m_nxt;
    e_stb = pe & (!alt_en | (cur == m_odd()));
    chk(smp_stb, e_stb, alt_en ? "R3" : "R2");
    if (e_stb) begin
      stb_cnt++;
      if (m_cnt != 0) bad_cnt++;
      chk(smp_data, d, "R4");
      chk(smp_valid, m_cnt == 0, "R9");
      chk(smp_phase_odd, m_odd(), tag);
      last_ph = smp_phase_odd;
    end else begin
      chk(smp_valid, 1'b0, "R9");
    end
    // model update
    old_odd = m_odd();
    rise = vs & !m_vsq;
    tog  = alt_en & m_armed & vb & (rise | m_pend);
    if (!alt_en || tog)        m_pend = 0;
    else if (m_armed && rise)  m_pend = 1;
    m_auto  = m_auto ^ tog;
    if (vb) m_inv = inv_in & alt_en;
    m_armed = m_armed | vb;
    m_vsq   = vs;
    if (m_odd() != old_odd) m_cnt = settle_len;
    else if (e_stb && m_cnt > 0) m_cnt--;
    if (pe) m_nxt = !cur; else if (ls) m_nxt = 1;
  endtask

  function automatic bit pat_en(input int pat, input int cyc);
    case (pat)
      0: return 1'b1;
      1: return (cyc % 2) == 0;
      2: return (cyc % 3) != 1;
      default: return ((cyc * 5) % 7) < 4;
    endcase
  endfunction

  task automatic line(input int n, input int pat);
    int k = 0;
    int cyc = 0;
    stb_cnt = 0; bad_cnt = 0;
    while (k < n) begin
      bit pe;
      pe = pat_en(pat, cyc);
      step(pe, pe && (k == 0), 0, 0, 8'((k + 1) * 13 + pat * 3 + cyc));
      if (pe) k++;
      cyc++;
    end
    step(0, 0, 0, 0, 8'h00);
  endtask

  task automatic blank(input bit with_vs);
    step(0, 0, 0, 1, 0);
    step(0, 0, with_vs, 1, 0);
    step(0, 0, with_vs, 1, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0);
  endtask

  task automatic vpulse_active();
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
  endtask

  initial begin
    rst_n = 0; pix_en = 0; line_start = 0; vsync = 0; vblank = 0;
    alt_en = 1; inv_in = 0; settle_len = 3'd2; pix_data = 0;
    model_reset();
    tag = "R10";
    repeat (3) @(negedge clk);
    chk(smp_stb, 1'b0, "R1");
    chk(smp_valid, 1'b0, "R1");
    chk(smp_phase_odd, 1'b1, "R1");
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(smp_stb, 1'b0, "R1");

    // R1 / R3: odd pixels after reset, half rate
    tag = "R1";
    line(8, 0);
    chk(8'(stb_cnt), 8'd4, "R3");
    chk(last_ph, 1'b1, "R1");

    // R7: vsync edge before first blanking is ignored
    tag = "R7";
    vpulse_active();
    blank(0);
    line(8, 1);
    chk(last_ph, 1'b1, "R7");

    // R5 / R9: armed edge in blanking flips to even, 2 invalid
    tag = "R5";
    blank(1);
    line(8, 0);
    chk(last_ph, 1'b0, "R5");
    chk(8'(bad_cnt), 8'd2, "R9");
    chk(8'(stb_cnt), 8'd4, "R3");

    // R6: edge outside blanking deferred
    tag = "R6";
    vpulse_active();
    line(6, 2);
    chk(last_ph, 1'b0, "R6");
    blank(0);
    line(6, 0);
    chk(last_ph, 1'b1, "R6");

    // R8: manual invert only latched in blanking
    tag = "R8";
    settle_len = 3'd0;
    inv_in = 1;
    line(6, 0);
    chk(last_ph, 1'b1, "R8");
    blank(0);
    line(6, 3);
    chk(last_ph, 1'b0, "R8");
    chk(8'(bad_cnt), 8'd0, "R9");
    inv_in = 0;
    line(6, 0);
    chk(last_ph, 1'b0, "R8");
    blank(0);
    line(6, 0);
    chk(last_ph, 1'b1, "R8");

    // R2 / R11: pass-through, no flips, invert ignored
    tag = "R11";
    alt_en = 0;
    inv_in = 1;
    blank(1);
    line(6, 1);
    chk(8'(stb_cnt), 8'd6, "R2");
    chk(last_ph, 1'b1, "R11");
    line(5, 3);
    chk(8'(stb_cnt), 8'd5, "R2");
    inv_in = 0;
    alt_en = 1;
    blank(0);
    line(6, 0);
    chk(last_ph, 1'b1, "R11");

    // Sweep of settle length and enable pattern
    tag = "R10";
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 4; p++) begin
        settle_len = 3'(s);
        blank(1);
        line(10, p);
        chk(8'(stb_cnt), 8'd5, "R3");
        chk(8'(bad_cnt), 8'((s < 5) ? s : 5), "R9");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule